// File: doc/BRIEF.md
# Configuration-Space Target Responder

This block answers configuration read and write cycles addressed to a single-function bus target. It watches the shared bus during every address phase. When its select line, the command lines and the two low address bits show that the cycle belongs to it, it claims the cycle. It then runs one data phase of fixed length against an internal store of 64 DWords, and byte enables pick which lanes are written.

The target claims with medium decode timing and always presents its ready signal in the same clock. It ends any attempt at a multi-phase transfer with a disconnect. While the boot-time load of the non-volatile store is still running, it answers every claimed cycle with a retry. It can pick up a new address phase in the clock straight after a data phase, with no idle clock in between. This holds whether the previous cycle went to this target or to another one.

The handshake outputs are active low and come with one shared drive-enable. Before the enable drops, they are driven high for one clock.

Top module: `pci_cfg_target`

## Requirements
- R1: A cycle is claimed only when, in its address phase, `idsel` is 1, `ad_in[1:0]` is 00 and `cbe_n` is 1010 (read) or 1011 (write). For any other cycle, `ctl_oe`, `ad_oe` and all handshake outputs stay inactive.
- R2: The DWord index is `ad_in[7:2]`. Bits `ad_in[10:8]` and `ad_in[31:11]` have no effect on which DWord is accessed.
- R3: Counting the address phase as edge E0, `devsel_n` goes low after edge E1.
- R4: `trdy_n` goes low after edge E2 and stays low until an edge where `irdy_n` is low. That edge completes the single data phase.
- R5: On a write, byte lane i (bits 8i+7:8i) is stored only if `cbe_n[i]` is 0 at the completing edge. A read returns the whole DWord.
- R6: If `frame_n` is low at edge E2, `stop_n` is asserted together with `trdy_n`. After the transfer, `devsel_n` and `stop_n` stay low and `trdy_n` stays high until `frame_n` is sampled high.
- R7: If `boot_busy` is 1 in the address phase, the target asserts `devsel_n` and then `stop_n` with `trdy_n` held high. It does not drive `ad_out` and does not store any data.
- R8: Bit 23 of DWord 1 (the fast back-to-back capable status flag) always reads 1, even after 0 is written to it.
- R9: After the last asserted clock of a claimed cycle, `devsel_n`, `trdy_n` and `stop_n` are driven high for exactly one clock with `ctl_oe` still 1. `ctl_oe` then drops.
- R10: An address phase that directly follows the final data phase of any transaction (`frame_n` high for one clock, `irdy_n` still low) is decoded and claimed with the same timing as after an idle bus.
- R11: On a claimed read that is not a retry, `ad_oe` is 1 from edge E1 until the completing edge. It is 0 on writes and on retries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| boot_busy | input | 1 | Boot-time store load in progress |
| frame_n | input | 1 | Cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select for this device |
| cbe_n | input | 4 | Command (address phase) / byte enables (data phase) |
| ad_in | input | 32 | Address/data bus as seen by the target |
| ad_out | output | 32 | Read data to drive onto the bus |
| ad_oe | output | 1 | Enable for driving ad_out |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, active low |
| ctl_oe | output | 1 | Drive enable for devsel_n, trdy_n, stop_n |

## Verification
A wrong internal phase shows at the ports within one clock. If a state is skipped or held, the drop of `devsel_n`, `trdy_n` or `ctl_oe` moves away from the edge the reference model expects. A latched command or retry flag that is wrong shows in the next clock as a wrong `ad_oe` or `stop_n`. A corrupted store index or a badly masked byte lane stays hidden until the DWord is read back, so each write is followed by a read of the same word and of aliased addresses.

// File: rtl/pci_cfg_target.sv
module pci_cfg_target #(
  parameter int REG_WORDS   = 64,
  parameter int STATUS_WORD = 1,
  parameter int FB2B_BIT    = 23,
  parameter logic [3:0] CMD_RD = 4'b1010,
  parameter logic [3:0] CMD_WR = 4'b1011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_busy,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  output logic        ctl_oe
);
  localparam int IDX_W = $clog2(REG_WORDS);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_CLAIM, S_XFER, S_HOLD, S_TURN} st_t;

  st_t              st;
  logic             frame_q, wr_q, retry_q, stop_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      mem [REG_WORDS];

  wire addr_phase = !frame_n && frame_q;
  wire cmd_cfg    = (cbe_n == CMD_RD) || (cbe_n == CMD_WR);
  wire hit        = addr_phase && idsel && (ad_in[1:0] == 2'b00) && cmd_cfg;
  wire done       = (st == S_XFER) && !irdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      frame_q <= 1'b1;
      wr_q    <= 1'b0;
      retry_q <= 1'b0;
      stop_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      frame_q <= frame_n;
      case (st)
        S_IDLE, S_TURN: begin
          if (hit) begin
            st      <= S_WAIT;
            idx_q   <= ad_in[IDX_W+1:2];
            wr_q    <= (cbe_n == CMD_WR);
            retry_q <= boot_busy;
          end else begin
            st <= S_IDLE;
          end
          stop_q <= 1'b0;
        end
        S_WAIT: st <= S_CLAIM;
        S_CLAIM: begin
          if (retry_q) begin
            st     <= S_HOLD;
            stop_q <= 1'b1;
          end else begin
            st     <= S_XFER;
            stop_q <= !frame_n;
          end
        end
        S_XFER: begin
          stop_q <= !frame_n;
          if (!irdy_n) st <= frame_n ? S_TURN : S_HOLD;
        end
        S_HOLD: begin
          if (frame_n) begin
            st     <= S_TURN;
            stop_q <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_WORDS; i++) mem[i] <= '0;
    end else if (done && wr_q) begin
      for (int b = 0; b < 4; b++)
        if (!cbe_n[b]) mem[idx_q][8*b +: 8] <= ad_in[8*b +: 8];
    end
  end

  wire [31:0] fixed_ones = (idx_q == IDX_W'(STATUS_WORD)) ? (32'd1 << FB2B_BIT) : 32'd0;

  assign ad_out   = mem[idx_q] | fixed_ones;
  assign devsel_n = !(st == S_CLAIM || st == S_XFER || st == S_HOLD);
  assign trdy_n   = !(st == S_XFER);
  assign stop_n   = !((st == S_XFER || st == S_HOLD) && stop_q);
  assign ctl_oe   = (st == S_CLAIM) || (st == S_XFER) || (st == S_HOLD) || (st == S_TURN);
  assign ad_oe    = !wr_q && !retry_q && (st == S_CLAIM || st == S_XFER);
endmodule

module pci_cfg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_n,
  input logic devsel_n,
  input logic trdy_n,
  input logic stop_n,
  input logic ctl_oe,
  input logic ad_oe
);
  p_medium_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> ($past(!frame_n, 2) && $past(frame_n, 3)));

  p_trdy_after_devsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n) |-> $past(!devsel_n));

  p_trdy_needs_devsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  p_driven_when_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n || !trdy_n || !stop_n) |-> ctl_oe);

  p_high_before_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_oe) |-> $past(devsel_n && trdy_n && stop_n));

  p_ad_only_when_claimed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !devsel_n);
endmodule

bind pci_cfg_target pci_cfg_target_chk u_chk (.*);

// File: tb/pci_cfg_target_test.sv
module pci_cfg_target_test;
  logic        clk = 0, rst_n = 0;
  logic        boot_busy = 0, frame_n = 1, irdy_n = 1, idsel = 0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, trdy_n, stop_n, ctl_oe;

  int vectors = 0, miscompares = 0;
  logic [31:0] model [64];

  localparam logic [3:0] RD = 4'b1010, WR = 4'b1011;
  localparam logic [4:0] IDLE_P = 5'b0_111_0;

  always #5 clk = ~clk;

  pci_cfg_target uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] pins();
    return {ctl_oe, devsel_n, trdy_n, stop_n, ad_oe};
  endfunction

  task automatic txn(input logic [3:0] cmd, input bit sel, input logic [31:0] addr,
                     input logic [3:0] be, input logic [31:0] wd, input bit burst,
                     input bit busy, input bit b2b, input string tag);
    bit claim = sel && addr[1:0] == 2'b00 && (cmd == RD || cmd == WR);
    bit wr = (cmd == WR);
    int idx = addr[7:2];
    logic [31:0] rexp = model[idx] | ((idx == 1) ? 32'h0080_0000 : 32'h0);
    frame_n = 0; irdy_n = 1; idsel = sel; cbe_n = cmd; ad_in = addr; boot_busy = busy;
    @(negedge clk);
    check({tag, " addr phase"}, 32'(pins()), 32'(IDLE_P));
    frame_n = !burst; irdy_n = 0; cbe_n = be; ad_in = wr ? wd : 32'hDEAD_BEEF;
    idsel = 0; boot_busy = 0;
    if (!claim) begin
      @(negedge clk);
      check({tag, " R1 unclaimed"}, 32'(pins()), 32'(IDLE_P));
      if (!b2b) begin
        irdy_n = 1;
        @(negedge clk);
        check({tag, " R1 unclaimed"}, 32'(pins()), 32'(IDLE_P));
      end
      return;
    end
    @(negedge clk);
    check({tag, " R3/R11 devsel"}, 32'(pins()), 32'({4'b1_011, !wr && !busy}));
    @(negedge clk);
    if (busy) begin
      check({tag, " R7 retry"}, 32'(pins()), 32'(5'b1_010_0));
      frame_n = 1;
      @(negedge clk);
      check({tag, " R9 release"}, 32'(pins()), 32'(5'b1_111_0));
      irdy_n = 1;
      @(negedge clk);
      check({tag, " R9 idle"}, 32'(pins()), 32'(IDLE_P));
      return;
    end
    check({tag, " R4/R6 trdy"}, 32'(pins()), 32'({3'b1_00, !burst, !wr}));
    if (!wr) check({tag, " R5 read data"}, ad_out, rexp);
    else for (int b = 0; b < 4; b++) if (!be[b]) model[idx][8*b +: 8] = wd[8*b +: 8];
    @(negedge clk);
    if (burst) begin
      check({tag, " R6 disconnect"}, 32'(pins()), 32'(5'b1_010_0));
      frame_n = 1;
      @(negedge clk);
    end
    check({tag, " R9 release"}, 32'(pins()), 32'(5'b1_111_0));
    if (b2b) return;
    irdy_n = 1;
    @(negedge clk);
    check({tag, " R9 idle"}, 32'(pins()), 32'(IDLE_P));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R9 reset state", 32'(pins()), 32'(IDLE_P));
    rst_n = 1;
    @(negedge clk);
    check("R9 after reset", 32'(pins()), 32'(IDLE_P));

    txn(WR, 1, 32'h0000_0014, 4'b0000, 32'hA5A5_1234, 0, 0, 0, "R5 full write");
    txn(RD, 1, 32'h0000_0014, 4'b0000, 0, 0, 0, 0, "R4 read back");
    txn(WR, 1, 32'h0000_0014, 4'b1110, 32'h0000_00FF, 0, 0, 0, "R5 byte lane0");
    txn(WR, 1, 32'h0000_0014, 4'b0011, 32'h7E6D_9999, 0, 0, 0, "R5 upper half");
    txn(RD, 1, 32'hFFFF_F314, 4'b1100, 0, 0, 0, 0, "R2 alias read");
    txn(WR, 1, 32'h0000_0004, 4'b0000, 32'h0000_0000, 0, 0, 0, "R8 clear status");
    txn(RD, 1, 32'h0000_0004, 4'b0000, 0, 0, 0, 0, "R8 status read");
    txn(RD, 0, 32'h0000_0014, 4'b0000, 0, 0, 0, 0, "R1 no idsel");
    txn(RD, 1, 32'h0000_0015, 4'b0000, 0, 0, 0, 0, "R1 ad10");
    txn(4'b0110, 1, 32'h0000_0014, 4'b0000, 0, 0, 0, 0, "R1 mem cmd");
    txn(WR, 1, 32'h0000_001C, 4'b0000, 32'h1357_9BDF, 1, 0, 0, "R6 burst write");
    txn(RD, 1, 32'h0000_001C, 4'b0000, 0, 1, 0, 0, "R6 burst read");
    txn(WR, 1, 32'h0000_001C, 4'b0000, 32'hFFFF_FFFF, 0, 1, 0, "R7 retry write");
    txn(RD, 1, 32'h0000_001C, 4'b0000, 0, 0, 1, 0, "R7 retry read");
    txn(RD, 1, 32'h0000_001C, 4'b0000, 0, 0, 0, 0, "R7 unchanged");
    txn(RD, 0, 32'h1000_0000, 4'b0000, 0, 0, 0, 1, "R10 other target");
    txn(WR, 1, 32'h0000_00FC, 4'b0000, 32'hCAFE_F00D, 0, 0, 1, "R10 b2b write top");
    txn(RD, 1, 32'h0000_07FC, 4'b0000, 0, 0, 0, 0, "R10 b2b read top");
    txn(RD, 1, 32'h0000_0014, 4'b0000, 0, 0, 0, 0, "R11 final read");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule